// File: doc/BRIEF.md
# Two-Port Memory Access Arbiter

This block shares one memory between two requesting ports. Each port raises its request line while it wants the memory and lowers it once its access is complete; lowering the line is the port's acknowledgement that it has been served. The first port owns the memory by default. Ownership passes to the second port only when the first port is idle or is just starting a new request in the same cycle, and it comes back as soon as the second port releases.

The owner is held in a register. That register drives one select signal, which steers the address, write data, byte enables and write strobe of the owning port onto the memory side. Read data from the memory goes to both ports unchanged, and each port gets a grant output. A one-cycle delayed copy of the first port's request gives a synchronous rising-edge detector. It tells a fresh request apart from one that has been held since an earlier cycle.

Top module: `arb_2port`

## Requirements
- R1: While rst_ni is low, p1_gnt_o is 1 and p2_gnt_o is 0. Reset also clears the delayed copy of p1_req_i to 0, so p1_req_i high in the first clock after reset counts as a fresh request.
- R2: When port 1 owns the memory, p2_req_i is 1 and p1_req_i is 0 at a clock edge, port 2 owns it after that edge.
- R3: When port 1 owns the memory and, at a clock edge, p2_req_i is 1 and p1_req_i is 1 but was 0 at the previous edge, port 2 owns it after that edge (port 2 wins a simultaneous fresh request).
- R4: When port 1 owns the memory and p1_req_i was already 1 at the previous edge and is still 1, port 1 keeps ownership whatever p2_req_i is.
- R5: When port 2 owns the memory and p2_req_i is 0 at a clock edge, port 1 owns it after that edge, whatever p1_req_i is.
- R6: When port 2 owns the memory and p2_req_i is 1 at a clock edge, port 2 keeps ownership whatever p1_req_i is.
- R7: When port 1 owns the memory and p2_req_i is 0, port 1 keeps ownership.
- R8: mem_addr_o, mem_wdata_o, mem_be_o and mem_we_o equal the fields of port 2 when p2_gnt_o is 1, and those of port 1 otherwise. They depend only on the registered owner and the port fields.
- R9: p1_rdata_o and p2_rdata_o both equal mem_rdata_i at all times.
- R10: Exactly one of p1_gnt_o and p2_gnt_o is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| p1_req_i | input | 1 | Port 1 request; low means served or idle |
| p1_addr_i | input | ADDR_W | Port 1 address |
| p1_wdata_i | input | DATA_W | Port 1 write data |
| p1_be_i | input | DATA_W/8 | Port 1 byte enables |
| p1_we_i | input | 1 | Port 1 write strobe |
| p1_gnt_o | output | 1 | Port 1 owns the memory |
| p1_rdata_o | output | DATA_W | Read data to port 1 |
| p2_req_i | input | 1 | Port 2 request; low means served or idle |
| p2_addr_i | input | ADDR_W | Port 2 address |
| p2_wdata_i | input | DATA_W | Port 2 write data |
| p2_be_i | input | DATA_W/8 | Port 2 byte enables |
| p2_we_i | input | 1 | Port 2 write strobe |
| p2_gnt_o | output | 1 | Port 2 owns the memory |
| p2_rdata_o | output | DATA_W | Read data to port 2 |
| mem_addr_o | output | ADDR_W | Address to memory |
| mem_wdata_o | output | DATA_W | Write data to memory |
| mem_be_o | output | DATA_W/8 | Byte enables to memory |
| mem_we_o | output | 1 | Write strobe to memory |
| mem_rdata_i | input | DATA_W | Read data from memory |

## Verification
The assertions check on every cycle the one-cycle ownership moves: handover to port 2 on an idle or fresh port 1, holding when port 1 is established, return on port 2 release, and holding while port 2 requests. They also check that the grants are mutually exclusive and that the memory-side fields and read data follow the owner. Some behaviour only the bench scenarios can show. One case is that reset really clears the delayed request copy, so a request held through reset looks fresh afterwards. Others are whole sequences in which port 2 waits several cycles behind an established port 1, and an asynchronous reset taken while port 2 owns the memory.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    OWN_P1 = 1'b0,
    OWN_P2 = 1'b1
  } owner_e;
endpackage

// File: rtl/arb_rise_det.sv
module arb_rise_det #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] held_o
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= '0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign held_o = sig_i & sig_q;
endmodule

// File: rtl/arb_owner_fsm.sv
module arb_owner_fsm
  import arb_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   p1_req_i,
  input  logic   p1_rise_i,
  input  logic   p2_req_i,
  output owner_e owner_o
);
  owner_e owner_q, owner_d;

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_P1: if (p2_req_i && (!p1_req_i || p1_rise_i)) owner_d = OWN_P2;
      OWN_P2: if (!p2_req_i) owner_d = OWN_P1;
      default: owner_d = OWN_P1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= OWN_P1;
    else         owner_q <= owner_d;
  end

  assign owner_o = owner_q;
endmodule

// File: rtl/arb_mux.sv
module arb_mux #(
  parameter int W = 8
) (
  input  logic         sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  assign y_o = sel_i ? b_i : a_i;
endmodule

// File: rtl/arb_2port.sv
module arb_2port
  import arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                p1_req_i,
  input  logic [ADDR_W-1:0]   p1_addr_i,
  input  logic [DATA_W-1:0]   p1_wdata_i,
  input  logic [DATA_W/8-1:0] p1_be_i,
  input  logic                p1_we_i,
  output logic                p1_gnt_o,
  output logic [DATA_W-1:0]   p1_rdata_o,
  input  logic                p2_req_i,
  input  logic [ADDR_W-1:0]   p2_addr_i,
  input  logic [DATA_W-1:0]   p2_wdata_i,
  input  logic [DATA_W/8-1:0] p2_be_i,
  input  logic                p2_we_i,
  output logic                p2_gnt_o,
  output logic [DATA_W-1:0]   p2_rdata_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic                mem_we_o,
  input  logic [DATA_W-1:0]   mem_rdata_i
);
  localparam int BE_W  = DATA_W / 8;
  localparam int BUS_W = ADDR_W + DATA_W + BE_W + 1;

  logic   p1_rise, p1_held;
  owner_e owner;
  logic   sel;

  arb_rise_det #(.W(1)) u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (p1_req_i),
    .rise_o (p1_rise),
    .held_o (p1_held)
  );

  arb_owner_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .p1_req_i  (p1_req_i),
    .p1_rise_i (p1_rise),
    .p2_req_i  (p2_req_i),
    .owner_o   (owner)
  );

  // select comes from the registered owner only
  assign sel = (owner == OWN_P2);

  logic [BUS_W-1:0] bus [2];
  logic [BUS_W-1:0] mem_bus;

  assign bus[0] = {p1_addr_i, p1_wdata_i, p1_be_i, p1_we_i};
  assign bus[1] = {p2_addr_i, p2_wdata_i, p2_be_i, p2_we_i};

  arb_mux #(.W(BUS_W)) u_mux (
    .sel_i (sel),
    .a_i   (bus[0]),
    .b_i   (bus[1]),
    .y_o   (mem_bus)
  );

  assign {mem_addr_o, mem_wdata_o, mem_be_o, mem_we_o} = mem_bus;

  assign p1_gnt_o   = ~sel;
  assign p2_gnt_o   = sel;
  assign p1_rdata_o = mem_rdata_i;
  assign p2_rdata_o = mem_rdata_i;

  logic unused_held;
  assign unused_held = p1_held;
endmodule

// File: rtl/arb_2port_chk.sv
module arb_2port_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                p1_req_i,
  input logic                p2_req_i,
  input logic                p1_gnt_o,
  input logic                p2_gnt_o,
  input logic [ADDR_W-1:0]   p1_addr_i,
  input logic [ADDR_W-1:0]   p2_addr_i,
  input logic [DATA_W-1:0]   p1_wdata_i,
  input logic [DATA_W-1:0]   p2_wdata_i,
  input logic [DATA_W/8-1:0] p1_be_i,
  input logic [DATA_W/8-1:0] p2_be_i,
  input logic                p1_we_i,
  input logic                p2_we_i,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic [DATA_W-1:0]   mem_wdata_o,
  input logic [DATA_W/8-1:0] mem_be_o,
  input logic                mem_we_o,
  input logic [DATA_W-1:0]   mem_rdata_i,
  input logic [DATA_W-1:0]   p1_rdata_o,
  input logic [DATA_W-1:0]   p2_rdata_o
);
  logic p1_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p1_prev <= 1'b0;
    else         p1_prev <= p1_req_i;
  end

  a_r1_reset_owner: assert property (@(posedge clk_i)
    !rst_ni |-> (p1_gnt_o && !p2_gnt_o));
  a_r2_idle_handover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_gnt_o && p2_req_i && !p1_req_i) |=> p2_gnt_o);
  a_r3_fresh_tie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_gnt_o && p2_req_i && p1_req_i && !p1_prev) |=> p2_gnt_o);
  a_r4_established_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_gnt_o && p1_req_i && p1_prev) |=> p1_gnt_o);
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p2_gnt_o && !p2_req_i) |=> p1_gnt_o);
  a_r6_p2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p2_gnt_o && p2_req_i) |=> p2_gnt_o);
  a_r7_no_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_gnt_o && !p2_req_i) |=> p1_gnt_o);
  a_r8_mux_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p2_gnt_o ? (mem_addr_o == p2_addr_i && mem_wdata_o == p2_wdata_i &&
                mem_be_o == p2_be_i && mem_we_o == p2_we_i)
             : (mem_addr_o == p1_addr_i && mem_wdata_o == p1_wdata_i &&
                mem_be_o == p1_be_i && mem_we_o == p1_we_i));
  a_r9_rdata_bcast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_rdata_o == mem_rdata_i) && (p2_rdata_o == mem_rdata_i));
  a_r10_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({p1_gnt_o, p2_gnt_o}) == 1);
endmodule

bind arb_2port arb_2port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .p1_req_i    (p1_req_i),
  .p2_req_i    (p2_req_i),
  .p1_gnt_o    (p1_gnt_o),
  .p2_gnt_o    (p2_gnt_o),
  .p1_addr_i   (p1_addr_i),
  .p2_addr_i   (p2_addr_i),
  .p1_wdata_i  (p1_wdata_i),
  .p2_wdata_i  (p2_wdata_i),
  .p1_be_i     (p1_be_i),
  .p2_be_i     (p2_be_i),
  .p1_we_i     (p1_we_i),
  .p2_we_i     (p2_we_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_be_o    (mem_be_o),
  .mem_we_o    (mem_we_o),
  .mem_rdata_i (mem_rdata_i),
  .p1_rdata_o  (p1_rdata_o),
  .p2_rdata_o  (p2_rdata_o)
);

// File: tb/tb_arb_2port.sv
module tb_arb_2port;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int NVEC   = 21;

  // {p1_req, p2_req, expected p2_gnt after the edge}
  localparam logic [2:0] VEC [NVEC] = '{
    3'b000, // R7 idle
    3'b100, // R7 p1 only
    3'b110, // R4 p1 established, p2 waits
    3'b110, // R4 still waiting
    3'b011, // R2 p1 dropped
    3'b111, // R6 p2 holds
    3'b100, // R5 release
    3'b000,
    3'b111, // R3 simultaneous fresh
    3'b100, // R5 release
    3'b000,
    3'b100,
    3'b011, // R2
    3'b000, // R5
    3'b011, // R2
    3'b011, // R6
    3'b000, // R5
    3'b000,
    3'b100,
    3'b000,
    3'b111  // R3 fresh pulse
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              p1_req = 1'b0, p2_req = 1'b0;
  logic [ADDR_W-1:0] p1_addr = 16'h1111, p2_addr = 16'h2222;
  logic [DATA_W-1:0] p1_wdata = 32'hAAAA_0001, p2_wdata = 32'h5555_0002;
  logic [BE_W-1:0]   p1_be = 4'h3, p2_be = 4'hC;
  logic              p1_we = 1'b1, p2_we = 1'b0;
  logic [DATA_W-1:0] mem_rdata = 32'hDEAD_BEEF;
  logic              p1_gnt, p2_gnt, mem_we;
  logic [DATA_W-1:0] p1_rdata, p2_rdata, mem_wdata;
  logic [ADDR_W-1:0] mem_addr;
  logic [BE_W-1:0]   mem_be;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  arb_2port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .p1_req_i(p1_req), .p1_addr_i(p1_addr), .p1_wdata_i(p1_wdata),
    .p1_be_i(p1_be), .p1_we_i(p1_we), .p1_gnt_o(p1_gnt), .p1_rdata_o(p1_rdata),
    .p2_req_i(p2_req), .p2_addr_i(p2_addr), .p2_wdata_i(p2_wdata),
    .p2_be_i(p2_be), .p2_we_i(p2_we), .p2_gnt_o(p2_gnt), .p2_rdata_o(p2_rdata),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_be_o(mem_be),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_owner(input string req, input logic exp_p2);
    chk(req, {62'd0, p1_gnt, p2_gnt}, {62'd0, ~exp_p2, exp_p2});
  endtask

  task automatic chk_mux(input string req);
    if (p2_gnt) chk(req, {mem_addr, mem_wdata, mem_be, mem_we},
                         {p2_addr, p2_wdata, p2_be, p2_we});
    else        chk(req, {mem_addr, mem_wdata, mem_be, mem_we},
                         {p1_addr, p1_wdata, p1_be, p1_we});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 5000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_owner("R1 reset state", 1'b0);
    chk_mux("R8 mux in reset");
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      p1_req = VEC[i][2];
      p2_req = VEC[i][1];
      @(negedge clk);
      chk_owner("R2-R7 vector owner", VEC[i][0]);
      chk_mux("R8 select follows owner");
      chk(p2_gnt ? "R10 grants" : "R10 grants", {63'd0, p1_gnt ^ p2_gnt}, 64'd1);
    end

    // R9 read data broadcast under both owners
    mem_rdata = 32'h0BAD_F00D;
    #1;
    chk("R9 rdata p1", {32'd0, p1_rdata}, {32'd0, mem_rdata});
    chk("R9 rdata p2", {32'd0, p2_rdata}, {32'd0, mem_rdata});

    // R8 field changes pass through combinationally while owned by port 2
    p2_addr = 16'hBEEF; p2_we = 1'b1; p1_addr = 16'h0F0F;
    #1;
    chk("R8 p2 addr", {48'd0, mem_addr}, {48'd0, 16'hBEEF});
    chk("R8 p2 we", {63'd0, mem_we}, 64'd1);

    // R1 async reset while port 2 owns
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_owner("R1 async reset from p2", 1'b0);
    chk("R8 p1 addr after reset", {48'd0, mem_addr}, {48'd0, 16'h0F0F});

    // R1 delayed copy cleared: p1 held high through reset reads as fresh
    p1_req = 1'b1; p2_req = 1'b1;
    repeat (2) @(negedge clk);
    chk_owner("R1 held in reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_owner("R1 R3 fresh after reset", 1'b1);

    // R4 long wait behind established port 1
    @(negedge clk);
    p2_req = 1'b0;            // back to p1
    @(negedge clk);
    chk_owner("R5 release", 1'b0);
    p2_req = 1'b1;            // p1 still high, established
    repeat (4) begin
      @(negedge clk);
      chk_owner("R4 p2 waits", 1'b0);
    end
    p1_req = 1'b0;
    @(negedge clk);
    chk_owner("R2 after p1 served", 1'b1);
    p1_req = 1'b1;            // p1 rises while p2 owns
    @(negedge clk);
    chk_owner("R6 p1 rise ignored", 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule